// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends asynchronous serial frames on one output line. The host writes a byte into a holding register. Whenever the shift stage is free, the byte moves into a shift register, and the holding register is reported empty again. The host can therefore queue the next byte while the current one is still on the line. The bit rate comes from an enable input, `baud_tick`. Each bit lasts a fixed number of those ticks, so the divisor that sets the bit rate stays outside the block.

The frame format is set through a control register:
- 7 or 8 data bits.
- An optional extra bit after the data bits, which is either a parity bit (even or odd) or a host-supplied multiprocessor flag.

The block decides what to do after a frame at the moment it enters the stop bit:
- If new data is pending, it is loaded then, and the next frame follows the stop bit with no idle gap.
- If nothing is pending, a transmit-end flag is raised and the line rests at 1 after the stop bit.

Both flags, gated by their enables, drive level interrupt outputs.

Top module: `sertx_core`

## Requirements
- R1: After reset, `txd` = 1, `buf_empty` = 1 and `tx_done` = 1. The control register is all zero, so `irq_empty` = 0 and `irq_done` = 0.
- R2: A write with `host_sel` = 0 stores `host_wdata` as transmit data. It clears `buf_empty` and `tx_done` at that clock edge, so both read 0 in the following cycle. A write with `host_sel` = 1 stores `host_wdata[6:0]` as control bits:
  - bit0 = 7-bit data
  - bit1 = parity enable
  - bit2 = odd parity
  - bit3 = multiprocessor-bit enable
  - bit4 = multiprocessor-bit value
  - bit5 = empty-interrupt enable
  - bit6 = end-interrupt enable
- R3: When the line is idle and data is pending, the next clock edge moves the data into the shift register, sets `buf_empty` to 1 and starts the start bit (`txd` = 0).
- R4: A frame goes out LSB first, in this order: start bit 0, then the data bits D0 upward (8 bits, or 7 when control bit0 = 1), then the extra bit if enabled, then stop bit 1.
- R5: The extra bit is present when parity or the multiprocessor bit is enabled.
  - Multiprocessor mode wins over parity and sends control bit4.
  - Parity covers the data bits only. With even parity, the data bits plus the parity bit hold an even number of ones. Odd parity inverts that bit.
- R6: Every bit lasts exactly 16 clock edges at which `baud_tick` = 1. While `baud_tick` stays 0, `txd` holds its value.
- R7: If `buf_empty` = 0 when the last data or extra bit ends, the pending data is loaded at that edge. `buf_empty` goes to 1, `tx_done` stays 0, and the next start bit begins right after the 16-tick stop bit.
- R8: If `buf_empty` = 1 at that edge, `tx_done` goes to 1. `txd` stays 1 through the stop bit and afterwards.
- R9: `irq_empty` = `buf_empty` AND control bit5, and `irq_done` = `tx_done` AND control bit6, both as levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Bit-rate enable; 16 ticks per bit |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 = transmit data, 1 = control |
| host_wdata | input | DATA_W | Host write data |
| txd | output | 1 | Serial output, idle high |
| buf_empty | output | 1 | Holding register free for new data |
| tx_done | output | 1 | Transmission ended, line idle |
| irq_empty | output | 1 | Empty interrupt request |
| irq_done | output | 1 | Transmit-end interrupt request |

## Verification
Timing of the results:
- A data write shows as `buf_empty` = 0 one cycle later.
- With no transfer pending, the start bit and the return of `buf_empty` to 1 appear one further cycle later.
- Each bit then occupies 16 cycles when `baud_tick` is held high.

The bench finds the first cycle of the start bit. It samples bit k at 8 + 16·k cycles after that cycle, at the falling clock edge, so every sample sits in the middle of a bit. The flags are checked at the middle of the stop bit, by which time the stop-entry decision has been registered. A chained pair of frames is sampled as one continuous run of bits, which proves there is no gap between them.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_EXTRA,
      ST_STOP
   } tx_state_e;

   typedef struct packed {
      logic end_ie;
      logic empty_ie;
      logic mp_val;
      logic mp_en;
      logic par_odd;
      logic par_en;
      logic short_len;
   } tx_ctrl_t;

   localparam int CTRL_W = 7;
endpackage

// File: rtl/sertx_regs.sv
module sertx_regs
   import sertx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic              host_sel,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              load,
   input  logic              end_set,
   output logic [DATA_W-1:0] hold_data,
   output tx_ctrl_t          ctrl,
   output logic              empty,
   output logic              done
);
   logic wr_data;
   logic wr_ctrl;

   assign wr_data = host_we && !host_sel;
   assign wr_ctrl = host_we && host_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_data <= '0;
         ctrl      <= '0;
         empty     <= 1'b1;
         done      <= 1'b1;
      end else begin
         if (wr_data) hold_data <= host_wdata;
         if (wr_ctrl) ctrl <= tx_ctrl_t'(host_wdata[CTRL_W-1:0]);
         // a fresh write outranks a same-cycle transfer
         if (wr_data)   empty <= 1'b0;
         else if (load) empty <= 1'b1;
         if (wr_data)      done <= 1'b0;
         else if (end_set) done <= 1'b1;
      end
   end
endmodule

// File: rtl/sertx_bitclk.sv
module sertx_bitclk #(
   parameter int TICKS_PER_BIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic baud_tick,
   output logic bit_end
);
   localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

   logic [CNT_W-1:0] cnt;

   assign bit_end = baud_tick && (cnt == LAST) && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (restart)       cnt <= '0;
      else if (baud_tick)     cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/sertx_seq.sv
module sertx_seq
   import sertx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              empty,
   input  logic [DATA_W-1:0] hold_data,
   input  logic              short_len,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              mp_en,
   input  logic              mp_val,
   input  logic              bit_end,
   output logic              load,
   output logic              end_set,
   output logic              restart,
   output logic              txd
);
   localparam int BIDX_W = $clog2(DATA_W);
   localparam logic [BIDX_W-1:0] IDX_FULL  = BIDX_W'(DATA_W - 1);
   localparam logic [BIDX_W-1:0] IDX_SHORT = BIDX_W'(DATA_W - 2);

   tx_state_e         state;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] masked;
   logic [BIDX_W-1:0] bidx;
   logic [BIDX_W-1:0] last_idx;
   logic              has_extra;
   logic              extra_bit;
   logic              chain;
   logic              going_stop;
   logic              new_extra;

   // the top data bit is dropped in short mode
   for (genvar g = 0; g < DATA_W; g++) begin : g_mask
      if (g == DATA_W - 1) begin : g_top
         assign masked[g] = hold_data[g] && !short_len;
      end else begin : g_low
         assign masked[g] = hold_data[g];
      end
   end

   assign new_extra  = mp_en ? mp_val : ((^masked) ^ par_odd);
   assign going_stop = bit_end &&
                       ((state == ST_DATA && bidx == last_idx && !has_extra) ||
                        state == ST_EXTRA);
   assign restart    = (state == ST_IDLE) && !empty;
   assign load       = restart || (going_stop && !empty);
   assign end_set    = going_stop && empty;

   always_comb begin
      unique case (state)
         ST_START: txd = 1'b0;
         ST_DATA:  txd = shreg[0];
         ST_EXTRA: txd = extra_bit;
         default:  txd = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         shreg     <= '0;
         bidx      <= '0;
         last_idx  <= IDX_FULL;
         has_extra <= 1'b0;
         extra_bit <= 1'b0;
         chain     <= 1'b0;
      end else begin
         if (load) begin
            shreg     <= masked;
            last_idx  <= short_len ? IDX_SHORT : IDX_FULL;
            has_extra <= par_en || mp_en;
            extra_bit <= new_extra;
         end else if (state == ST_DATA && bit_end) begin
            shreg <= shreg >> 1;
         end
         if (going_stop) chain <= !empty;
         unique case (state)
            ST_IDLE:  if (!empty) state <= ST_START;
            ST_START: if (bit_end) begin
               state <= ST_DATA;
               bidx  <= '0;
            end
            ST_DATA:  if (bit_end) begin
               if (bidx == last_idx) state <= has_extra ? ST_EXTRA : ST_STOP;
               else                  bidx  <= bidx + 1'b1;
            end
            ST_EXTRA: if (bit_end) state <= ST_STOP;
            ST_STOP:  if (bit_end) state <= chain ? ST_START : ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sertx_core.sv
module sertx_core
   import sertx_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int TICKS_PER_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              host_we,
   input  logic              host_sel,
   input  logic [DATA_W-1:0] host_wdata,
   output logic              txd,
   output logic              buf_empty,
   output logic              tx_done,
   output logic              irq_empty,
   output logic              irq_done
);
   if (DATA_W < CTRL_W || DATA_W > 16) begin : g_bad_width
      $error("sertx_core: DATA_W must be within 7..16");
   end
   if (TICKS_PER_BIT < 2) begin : g_bad_ticks
      $error("sertx_core: TICKS_PER_BIT must be at least 2");
   end

   logic [DATA_W-1:0] hold_data;
   tx_ctrl_t          ctrl;
   logic              load;
   logic              end_set;
   logic              restart;
   logic              bit_end;

   sertx_regs #(.DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_sel   (host_sel),
      .host_wdata (host_wdata),
      .load       (load),
      .end_set    (end_set),
      .hold_data  (hold_data),
      .ctrl       (ctrl),
      .empty      (buf_empty),
      .done       (tx_done)
   );

   sertx_bitclk #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_bitclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .baud_tick (baud_tick),
      .bit_end   (bit_end)
   );

   sertx_seq #(.DATA_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .empty     (buf_empty),
      .hold_data (hold_data),
      .short_len (ctrl.short_len),
      .par_en    (ctrl.par_en),
      .par_odd   (ctrl.par_odd),
      .mp_en     (ctrl.mp_en),
      .mp_val    (ctrl.mp_val),
      .bit_end   (bit_end),
      .load      (load),
      .end_set   (end_set),
      .restart   (restart),
      .txd       (txd)
   );

   assign irq_empty = buf_empty && ctrl.empty_ie;
   assign irq_done  = tx_done && ctrl.end_ie;
endmodule

// File: rtl/sertx_core_chk.sv
module sertx_core_chk (
   input logic clk,
   input logic rst_n,
   input logic host_we,
   input logic host_sel,
   input logic txd,
   input logic buf_empty,
   input logic tx_done,
   input logic irq_empty,
   input logic irq_done
);
   a_r2_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && !host_sel) |=> (!buf_empty && !tx_done));

   a_r3_load_not_ended: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buf_empty) |-> !tx_done);

   a_r8_end_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> txd);

   a_r8_end_only_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_done) |-> buf_empty);

   a_r9_empty_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_empty |-> !irq_empty);

   a_r9_end_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_done |-> !irq_done);
endmodule

bind sertx_core sertx_core_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_we   (host_we),
   .host_sel  (host_sel),
   .txd       (txd),
   .buf_empty (buf_empty),
   .tx_done   (tx_done),
   .irq_empty (irq_empty),
   .irq_done  (irq_done)
);

// File: tb/sim_sertx_core.sv
`timescale 1ns/1ps
module sim_sertx_core;
   localparam int DW  = 8;
   localparam int TPB = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_hold = 1'b0;
   logic          baud_tick;
   logic          host_we = 1'b0;
   logic          host_sel = 1'b0;
   logic [DW-1:0] host_wdata = '0;
   logic          txd, buf_empty, tx_done, irq_empty, irq_done;

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   logic [31:0] got_bits;
   logic [31:0] done_at;
   logic [31:0] empty_at;

   assign baud_tick = !tick_hold;

   always #2.5 clk = ~clk;

   sertx_core #(.DATA_W(DW), .TICKS_PER_BIT(TPB)) u0 (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
      .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done),
      .irq_empty(irq_empty), .irq_done(irq_done)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [DW-1:0] d);
      @(negedge clk);
      host_we = 1'b1; host_sel = sel; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   // expected frame, bit 0 = start bit
   task automatic frame(input logic [6:0] c, input logic [DW-1:0] d,
                        output logic [15:0] bits, output int n);
      int nd;
      logic [DW-1:0] m;
      logic ex;
      nd = c[0] ? DW - 1 : DW;
      m  = c[0] ? (d & 8'h7F) : d;
      ex = c[3] ? c[4] : ((^m) ^ c[2]);
      bits = '0;
      for (int i = 0; i < nd; i++) bits[1+i] = d[i];
      n = nd + 1;
      if (c[1] || c[3]) begin
         bits[n] = ex;
         n++;
      end
      bits[n] = 1'b1;
      n++;
   endtask

   // find the first start-bit cycle, then sample mid-bit for nb bits
   task automatic capture(input int nb);
      int w;
      w = 0;
      got_bits = '0; done_at = '0; empty_at = '0;
      @(negedge clk);
      while (txd !== 1'b0 && w < 200) begin
         @(negedge clk);
         w++;
      end
      repeat (8) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         if (i > 0) repeat (TPB) @(negedge clk);
         got_bits[i] = txd;
         done_at[i]  = tx_done;
         empty_at[i] = buf_empty;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         fails++;
         $display("FAIL watchdog expired");
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] eb, eb2;
      int n, n2;
      logic [7:0] dset [5];
      dset[0] = 8'h00; dset[1] = 8'hFF; dset[2] = 8'hA5;
      dset[3] = 8'h3C; dset[4] = 8'h81;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 txd", {31'd0, txd}, 32'd1);
      chk("R1 buf_empty", {31'd0, buf_empty}, 32'd1);
      chk("R1 tx_done", {31'd0, tx_done}, 32'd1);
      chk("R1 irqs", {30'd0, irq_empty, irq_done}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2/R3 write-to-start latency
      wr(1'b0, 8'h55);
      chk("R2 empty cleared", {31'd0, buf_empty}, 32'd0);
      chk("R2 done cleared", {31'd0, tx_done}, 32'd0);
      @(negedge clk);
      chk("R3 start bit", {31'd0, txd}, 32'd0);
      chk("R3 empty set on load", {31'd0, buf_empty}, 32'd1);
      repeat (12 * TPB) @(negedge clk);

      // R4/R5/R8 sweep over all formats
      for (int f = 0; f < 32; f++) begin
         for (int k = 0; k < 5; k++) begin
            wr(1'b1, {3'b000, 5'(f)});
            frame(7'(f), dset[k], eb, n);
            wr(1'b0, dset[k]);
            capture(n);
            chk($sformatf("R4 R5 frame fmt=%0d d=%0h", f, dset[k]),
                got_bits, {16'd0, eb} & ((32'd1 << n) - 1));
            chk("R8 end flag at stop", {31'd0, done_at[n-1]}, 32'd1);
            repeat (TPB) @(negedge clk);
            chk("R8 idle mark", {31'd0, txd}, 32'd1);
         end
      end

      // R7 back-to-back chaining (8 data bits, odd parity)
      wr(1'b1, 8'h06);
      frame(7'h06, 8'hC3, eb, n);
      frame(7'h06, 8'h1E, eb2, n2);
      wr(1'b0, 8'hC3);
      @(negedge clk);
      wr(1'b0, 8'h1E);
      chk("R7 refill pending", {30'd0, buf_empty, tx_done}, 32'd0);
      capture(n + n2);
      chk("R7 chained frames", got_bits,
          (({16'd0, eb2} << n) | {16'd0, eb}) & ((32'd1 << (n + n2)) - 1));
      chk("R7 no end flag between", {31'd0, done_at[n-1]}, 32'd0);
      chk("R7 empty after chain load", {31'd0, empty_at[n-1]}, 32'd1);
      chk("R8 end flag after last", {31'd0, done_at[n+n2-1]}, 32'd1);
      repeat (TPB) @(negedge clk);

      // R9 interrupt gating
      wr(1'b1, 8'h60);
      chk("R9 irqs idle", {30'd0, irq_empty, irq_done}, 32'd3);
      wr(1'b0, 8'h0F);
      chk("R9 irqs after write", {30'd0, irq_empty, irq_done}, 32'd0);
      @(negedge clk);
      chk("R9 empty irq after load", {30'd0, irq_empty, irq_done}, 32'd2);
      repeat (11 * TPB) @(negedge clk);
      chk("R9 end irq at stop", {31'd0, irq_done}, 32'd1);
      repeat (2 * TPB) @(negedge clk);
      wr(1'b1, 8'h00);
      chk("R9 irqs disabled", {30'd0, irq_empty, irq_done}, 32'd0);

      // R6 ticks gate bit timing
      tick_hold = 1'b1;
      wr(1'b0, 8'hFF);
      @(negedge clk);
      repeat (100) @(negedge clk);
      chk("R6 start held without ticks", {31'd0, txd}, 32'd0);
      tick_hold = 1'b0;
      repeat (TPB - 1) @(negedge clk);
      chk("R6 start still low at tick 15", {31'd0, txd}, 32'd0);
      @(negedge clk);
      chk("R6 D0 after 16 ticks", {31'd0, txd}, 32'd1);
      repeat (12 * TPB) @(negedge clk);
      chk("R8 final idle", {30'd0, txd, tx_done}, 32'd3);

      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule